// File: doc/BRIEF.md
# Thermal Printhead Line Interface

This block moves one line of bi-level print data into a thermal printhead and then fires the heating strobes for that line. The print data sits in a line buffer with an asynchronous read port. The block presents a pixel index and takes the addressed bit back in the same cycle. Each pixel goes out on a serial data line under a shift clock whose low and high phases each last a programmable number of ticks. After the last pixel, a latch pulse of programmable width transfers the shifted line into the head's drivers. Strobe groups 0, 1, 2 and 3 then heat one after another, in ascending index, each for a programmable width.

A split (latchless) mode drops the latch pulse, so the first strobe follows the last shift clock directly. A line timer fixes the spacing of line starts. The requested period is held between a minimum and a maximum (by default 5 ms and 40 ms at a 1 MHz tick). If the shift and heat work of a line does not fit in the period, the line takes as long as that work needs and a sticky overrun flag is raised. A start request that arrives while a line is still running is held. The held line begins as soon as the current period ends.

All configuration inputs are captured when a line begins and held for the whole of that line.

Top module: `tph_line_if`

## Requirements
- R1: After reset, sclk_o, latch_o, strb_o, ovr_o and rd_addr_o are all zero.
- R2: A line starts in the cycle after start is accepted. Each pixel k of an N-pixel line occupies 2H cycles: sclk_o is low for H cycles, then high for H cycles. sdata_o holds buffer bit k over all 2H cycles. rd_addr_o shows index k in the cycle before pixel k begins, and shows 0 outside a shift.
- R3: A line length of 0 is taken as 1, and a length above MAX_PIX is taken as MAX_PIX. A timing field (half period, latch width, strobe width) of 0 is taken as 1.
- R4: In latched mode, latch_o is high for L cycles. The latch begins in the cycle right after the last high shift-clock cycle and ends in the cycle before the first strobe.
- R5: In split mode, latch_o never rises, and the first strobe begins in the cycle right after the last high shift-clock cycle.
- R6: Group select 0 gives 1 strobe group, 1 gives 2, and 2 or 3 gives 4 (capped at NGRP). Groups fire in ascending index, each high for W cycles, and at most one strobe line is high at any time.
- R7: Consecutive lines start P cycles apart, where P is period_i clamped into [PER_MIN, PER_MAX]. Outside shift, latch and strobe, all outputs stay low until the period ends.
- R8: When the busy time B = 2HN + L (latched mode only) + G·W exceeds P, the line lasts B cycles and ovr_o becomes 1 and stays 1 until reset. When B equals P, ovr_o stays 0.
- R9: A start request made while a line runs is held. The held line begins at the first cycle after the period ends. Several requests made during one line produce a single new line.
- R10: Configuration inputs are captured in the accept cycle. Changing them mid-line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timing tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to print one line |
| split_i | input | 1 | 1 = latchless split mode, 0 = latched mode |
| grp_sel_i | input | 2 | Strobe group count select (0:1, 1:2, 2/3:4) |
| pix_len_i | input | PIX_W | Pixels per line |
| half_i | input | TW | Shift clock half period in ticks |
| latch_w_i | input | TW | Latch pulse width in ticks |
| strb_w_i | input | TW | Width of each strobe in ticks |
| period_i | input | PER_W | Requested line period in ticks |
| rd_data_i | input | 1 | Line buffer bit at rd_addr_o |
| rd_addr_o | output | ADDR_W | Line buffer pixel index |
| sdata_o | output | 1 | Serial print data |
| sclk_o | output | 1 | Shift clock |
| latch_o | output | 1 | Latch pulse |
| strb_o | output | NGRP | Strobe lines, one per group |
| ovr_o | output | 1 | Sticky line period overrun flag |

## Verification
The main sweep covers every line length class with both half-period settings, at both modes and at all four group selects. It uses line lengths of 0, 1, 2, a middle value, the maximum and an oversized value, and half periods from 0 to 3. Latch and strobe widths of 0 come up along the way. Each cycle of each line is compared with a waveform computed from the pixel, latch and strobe arithmetic. This separates off-by-one errors in pixel phase, latch placement and strobe order, and it also catches a wrong clamp on length or width. Chained lines with held requests and a mid-line configuration change show how period clamping at both ends, collapsing of requests and configuration capture behave. Two overrun lines, one exceeding its period and one exactly equal to it, tell the flag's strict comparison apart from an inclusive one.

// File: rtl/tph_pkg.sv
package tph_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FIRE  = 2'd2,
    ST_WAIT  = 2'd3
  } tph_state_e;
endpackage

// File: rtl/tph_shifter.sv
module tph_shifter #(
  parameter int PIX_W  = 12,
  parameter int ADDR_W = 11,
  parameter int TW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              run,
  input  logic [PIX_W-1:0]  npix,
  input  logic [TW-1:0]     half,
  input  logic              rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sdata,
  output logic              sclk,
  output logic              last
);
  logic [PIX_W-1:0] pix_q, pix_d;
  logic [TW-1:0]    hcnt_q, hcnt_d;
  logic             ph_q, ph_d;
  logic             sd_q, sd_d;
  logic             hend;
  logic [PIX_W-1:0] pix_nxt;

  assign hend    = (hcnt_q == half - TW'(1));
  assign pix_nxt = pix_q + PIX_W'(1);
  assign last    = run && ph_q && hend && (pix_q == npix - PIX_W'(1));
  assign rd_addr = run ? pix_nxt[ADDR_W-1:0] : '0;
  assign sclk    = run && ph_q;
  assign sdata   = sd_q;

  always_comb begin
    pix_d  = pix_q;
    hcnt_d = hcnt_q;
    ph_d   = ph_q;
    sd_d   = sd_q;
    if (go) begin
      pix_d  = '0;
      hcnt_d = '0;
      ph_d   = 1'b0;
      sd_d   = rd_data;
    end else if (run) begin
      if (!hend) begin
        hcnt_d = hcnt_q + TW'(1);
      end else begin
        hcnt_d = '0;
        if (!ph_q) begin
          ph_d = 1'b1;
        end else if (last) begin
          ph_d  = 1'b0;
          pix_d = '0;
        end else begin
          ph_d  = 1'b0;
          pix_d = pix_nxt;
          sd_d  = rd_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      hcnt_q <= '0;
      ph_q   <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      pix_q  <= pix_d;
      hcnt_q <= hcnt_d;
      ph_q   <= ph_d;
      sd_q   <= sd_d;
    end
  end
endmodule

// File: rtl/tph_fire.sv
module tph_fire #(
  parameter int NGRP   = 4,
  parameter int TW     = 16,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              run,
  input  logic              split,
  input  logic [SLOT_W-1:0] ngrp,
  input  logic [TW-1:0]     latw,
  input  logic [TW-1:0]     strw,
  output logic              latch,
  output logic [NGRP-1:0]   strb,
  output logic              last
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic [TW-1:0]     width;
  logic              wend;

  assign width = (slot_q == '0) ? latw : strw;
  assign wend  = (cnt_q == width - TW'(1));
  assign last  = run && wend && (slot_q == ngrp);
  assign latch = run && (slot_q == '0);

  for (genvar g = 0; g < NGRP; g++) begin : g_strb
    assign strb[g] = run && (slot_q == SLOT_W'(g + 1));
  end

  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    if (go) begin
      slot_d = split ? SLOT_W'(1) : '0;
      cnt_d  = '0;
    end else if (run) begin
      if (wend) begin
        cnt_d  = '0;
        slot_d = slot_q + SLOT_W'(1);
      end else begin
        cnt_d = cnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      slot_q <= slot_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/tph_line_timer.sv
module tph_line_timer #(
  parameter int PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cand,
  input  logic             fire_last,
  input  logic [PER_W-1:0] period,
  output logic             line_end,
  output logic             ovr
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] pm1;
  logic             ovr_q, ovr_d;

  assign pm1      = period - PER_W'(1);
  assign line_end = cand && (cnt_q >= pm1);
  assign ovr      = ovr_q;

  always_comb begin
    cnt_d = cnt_q;
    if (go) begin
      cnt_d = '0;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + PER_W'(1);
    end
    ovr_d = ovr_q | (fire_last && (cnt_q > pm1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end
endmodule

// File: rtl/tph_line_if.sv
module tph_line_if import tph_pkg::*; #(
  parameter int MAX_PIX = 2048,
  parameter int NGRP    = 4,
  parameter int TW      = 16,
  parameter int PER_W   = 24,
  parameter int PER_MIN = 5000,
  parameter int PER_MAX = 40000,
  localparam int ADDR_W = $clog2(MAX_PIX),
  localparam int PIX_W  = $clog2(MAX_PIX + 1),
  localparam int SLOT_W = $clog2(NGRP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              split_i,
  input  logic [1:0]        grp_sel_i,
  input  logic [PIX_W-1:0]  pix_len_i,
  input  logic [TW-1:0]     half_i,
  input  logic [TW-1:0]     latch_w_i,
  input  logic [TW-1:0]     strb_w_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic              rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              latch_o,
  output logic [NGRP-1:0]   strb_o,
  output logic              ovr_o
);
  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rstn_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rstn_s = rs_q[1];

  tph_state_e st_q, st_d;
  logic pend_q, pend_d;
  logic go, want, fire_go, sh_last, fire_last, line_end, cand;

  // Line configuration captured at line start
  logic [PIX_W-1:0]  npix_q, npix_d;
  logic [TW-1:0]     half_q, half_d, latw_q, latw_d, strw_q, strw_d;
  logic [PER_W-1:0]  per_q, per_d;
  logic [SLOT_W-1:0] ngrp_q, ngrp_d;
  logic              split_q;
  int                gsel;

  always_comb begin
    npix_d = (pix_len_i == '0) ? PIX_W'(1) :
             (pix_len_i > PIX_W'(MAX_PIX)) ? PIX_W'(MAX_PIX) : pix_len_i;
    half_d = (half_i    == '0) ? TW'(1) : half_i;
    latw_d = (latch_w_i == '0) ? TW'(1) : latch_w_i;
    strw_d = (strb_w_i  == '0) ? TW'(1) : strb_w_i;
    per_d  = (period_i < PER_W'(PER_MIN)) ? PER_W'(PER_MIN) :
             (period_i > PER_W'(PER_MAX)) ? PER_W'(PER_MAX) : period_i;
    case (grp_sel_i)
      2'd0:    gsel = 1;
      2'd1:    gsel = 2;
      default: gsel = 4;
    endcase
    ngrp_d = SLOT_W'((gsel < NGRP) ? gsel : NGRP);
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      npix_q  <= PIX_W'(1);
      half_q  <= TW'(1);
      latw_q  <= TW'(1);
      strw_q  <= TW'(1);
      per_q   <= PER_W'(PER_MIN);
      ngrp_q  <= SLOT_W'(1);
      split_q <= 1'b0;
    end else if (go) begin
      npix_q  <= npix_d;
      half_q  <= half_d;
      latw_q  <= latw_d;
      strw_q  <= strw_d;
      per_q   <= per_d;
      ngrp_q  <= ngrp_d;
      split_q <= split_i;
    end
  end

  // Line sequencing
  assign want    = start_i || pend_q;
  assign cand    = (st_q == ST_WAIT) || ((st_q == ST_FIRE) && fire_last);
  assign go      = want && ((st_q == ST_IDLE) || line_end);
  assign fire_go = (st_q == ST_SHIFT) && sh_last;

  always_comb begin
    st_d   = st_q;
    pend_d = go ? 1'b0 : (pend_q || start_i);
    case (st_q)
      ST_IDLE:  if (go) st_d = ST_SHIFT;
      ST_SHIFT: if (sh_last) st_d = ST_FIRE;
      ST_FIRE: begin
        if (fire_last) begin
          if (line_end) st_d = go ? ST_SHIFT : ST_IDLE;
          else          st_d = ST_WAIT;
        end
      end
      default: if (line_end) st_d = go ? ST_SHIFT : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  tph_shifter #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .TW(TW)) u_shift (
    .clk(clk), .rst_n(rstn_s), .go(go), .run(st_q == ST_SHIFT),
    .npix(npix_q), .half(half_q), .rd_data(rd_data_i),
    .rd_addr(rd_addr_o), .sdata(sdata_o), .sclk(sclk_o), .last(sh_last)
  );

  tph_fire #(.NGRP(NGRP), .TW(TW), .SLOT_W(SLOT_W)) u_fire (
    .clk(clk), .rst_n(rstn_s), .go(fire_go), .run(st_q == ST_FIRE),
    .split(split_q), .ngrp(ngrp_q), .latw(latw_q), .strw(strw_q),
    .latch(latch_o), .strb(strb_o), .last(fire_last)
  );

  tph_line_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rstn_s), .go(go), .cand(cand), .fire_last(fire_last),
    .period(per_q), .line_end(line_end), .ovr(ovr_o)
  );
endmodule

// File: rtl/tph_line_if_chk.sv
module tph_line_if_chk #(
  parameter int NGRP   = 4,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              split_q,
  input logic [SLOT_W-1:0] ngrp_q,
  input logic              sclk_o,
  input logic              latch_o,
  input logic [NGRP-1:0]   strb_o,
  input logic              ovr_o
);
  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb_o)); // R6

  AST_GRP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_o >> ngrp_q) == '0)); // R6

  AST_LATCH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> (!sclk_o && (strb_o == '0))); // R4

  AST_SPLIT_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    split_q |-> !latch_o); // R5

  AST_SCLK_NO_HEAT: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> (strb_o == '0)); // R2

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> ovr_o); // R8
endmodule

bind tph_line_if tph_line_if_chk #(.NGRP(NGRP), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .split_q(split_q), .ngrp_q(ngrp_q),
  .sclk_o(sclk_o), .latch_o(latch_o), .strb_o(strb_o), .ovr_o(ovr_o)
);

// File: tb/tph_line_if_bench.sv
module tph_line_if_bench;
  localparam int MAXP = 16;
  localparam int NG   = 4;
  localparam int TWB  = 8;
  localparam int PWB  = 16;
  localparam int PMIN = 40;
  localparam int PMAX = 300;

  logic clk, rst_n;
  logic i_start, i_split, rd_data, sdata, sclk, latch, ovr;
  logic [1:0] i_sel;
  logic [4:0] i_pix;
  logic [TWB-1:0] i_half, i_latw, i_strw;
  logic [PWB-1:0] i_per;
  logic [3:0] rd_addr;
  logic [NG-1:0] strb;
  logic pbuf [0:MAXP-1];

  assign rd_data = pbuf[rd_addr];

  tph_line_if #(.MAX_PIX(MAXP), .NGRP(NG), .TW(TWB), .PER_W(PWB),
                .PER_MIN(PMIN), .PER_MAX(PMAX)) u_tph_line_if (
    .clk(clk), .rst_n(rst_n), .start_i(i_start), .split_i(i_split),
    .grp_sel_i(i_sel), .pix_len_i(i_pix), .half_i(i_half),
    .latch_w_i(i_latw), .strb_w_i(i_strw), .period_i(i_per),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .sdata_o(sdata),
    .sclk_o(sclk), .latch_o(latch), .strb_o(strb), .ovr_o(ovr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk, n_bad;
  bit done;
  int e_n, e_h, e_l, e_w, e_g, e_split, e_P, e_B, e_peff;
  int p1, p2, chg;
  string tagx;
  logic [4:0] c_pix; logic [TWB-1:0] c_half, c_latw, c_strw;
  logic [PWB-1:0] c_per; logic [1:0] c_sel; logic c_split;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic calc();
    e_n = (i_pix == 0) ? 1 : ((i_pix > MAXP) ? MAXP : int'(i_pix));
    e_h = (i_half == 0) ? 1 : int'(i_half);
    e_l = (i_latw == 0) ? 1 : int'(i_latw);
    e_w = (i_strw == 0) ? 1 : int'(i_strw);
    e_g = (i_sel == 0) ? 1 : ((i_sel == 1) ? 2 : 4);
    e_split = int'(i_split);
    e_P = (i_per < PMIN) ? PMIN : ((i_per > PMAX) ? PMAX : int'(i_per));
    e_B = 2 * e_h * e_n + (e_split ? 0 : e_l) + e_g * e_w;
    e_peff = (e_B > e_P) ? e_B : e_P;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < MAXP; i++) pbuf[i] = (((i * 5 + seed) % 7) > 3);
  endtask

  // Expected {sclk, latch, strb} and sdata for line cycle k
  task automatic check_cycle(input int k);
    int shift_len, j, lx, s, ev, ed;
    string reg_tag;
    shift_len = 2 * e_h * e_n;
    lx = e_split ? 0 : e_l;
    ev = 0; ed = -1;
    if (k < shift_len) begin
      ev = (((k % (2 * e_h)) >= e_h) ? 1 : 0) << 5;
      ed = int'(pbuf[k / (2 * e_h)]);
      reg_tag = "R2";
    end else if (k < e_B) begin
      j = k - shift_len;
      if (j < lx) begin
        ev = 1 << 4; reg_tag = "R4";
      end else begin
        s = (j - lx) / e_w;
        ev = 1 << s;
        reg_tag = e_split ? "R5/R6" : "R6";
      end
    end else begin
      reg_tag = (k < e_peff) ? "R7" : "R9";
    end
    check($sformatf("%s%s k=%0d", reg_tag, tagx, k),
          int'({sclk, latch, strb}), ev);
    if (ed >= 0) check($sformatf("R2%s data k=%0d", tagx, k), int'(sdata), ed);
    if (k > 0 && k < shift_len && (k % (2 * e_h)) == 2 * e_h - 1 &&
        k / (2 * e_h) + 1 < e_n)
      check($sformatf("R2%s addr k=%0d", tagx, k), int'(rd_addr),
            k / (2 * e_h) + 1);
  endtask

  task automatic check_line(input int upto);
    for (int k = 0; k < upto; k++) begin
      @(negedge clk);
      check_cycle(k);
      i_start = (k == p1 || k == p2);
      if (k == chg) begin
        i_pix = c_pix; i_half = c_half; i_latw = c_latw; i_strw = c_strw;
        i_per = c_per; i_sel = c_sel; i_split = c_split;
      end
    end
    i_start = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    i_start = 1'b1;
    calc();
    @(posedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; i_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic setcfg(input int pix, input int h, input int sp, input int sel,
                        input int l, input int w, input int per);
    i_pix = 5'(pix); i_half = TWB'(h); i_split = sp[0]; i_sel = 2'(sel);
    i_latw = TWB'(l); i_strw = TWB'(w); i_per = PWB'(per);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int pixv[6];
    n_chk = 0; n_bad = 0; done = 0;
    p1 = -1; p2 = -1; chg = -1; tagx = "";
    fill(0);
    setcfg(1, 1, 0, 0, 1, 1, 0);
    do_reset();

    // R1: reset state
    check("R1 outputs", int'({sclk, latch, strb}), 0);
    check("R1 ovr", int'(ovr), 0);
    check("R1 addr", int'(rd_addr), 0);

    // Sweep: length, half period, mode, group select (R2..R6, R3 clamps)
    pixv = '{0, 1, 2, 5, 16, 21};
    foreach (pixv[pi]) begin
      for (int h = 0; h < 4; h++) begin
        for (int sp = 0; sp < 2; sp++) begin
          for (int sel = 0; sel < 4; sel++) begin
            fill(pi * 3 + h + sel);
            setcfg(pixv[pi], h, sp, sel, h, sel, 0);
            tagx = (pixv[pi] == 0 || pixv[pi] > MAXP || h == 0 || sel == 0)
                   ? "/R3" : "";
            kick();
            check_line(e_peff + 2);
          end
        end
      end
    end
    tagx = "";

    // R9 + R10: held requests during line A, config changed mid-line
    do_reset();
    fill(11);
    setcfg(6, 2, 0, 2, 3, 2, 100);
    c_pix = 5'd4; c_half = 8'd1; c_split = 1'b1; c_sel = 2'd1;
    c_latw = 8'd9; c_strw = 8'd5; c_per = 16'd500;
    p1 = 3; p2 = 4; chg = 2; tagx = "/R10";
    kick();
    check_line(e_peff);
    // line B: period 500 clamps to PMAX (R7); one held request at k=5
    p1 = 5; p2 = -1; chg = -1; tagx = "/R7";
    calc();
    check_line(e_peff);
    // line C follows exactly at PMAX, then no further line (R9 collapse)
    p1 = -1; tagx = "/R9";
    calc();
    check_line(e_peff + 4);
    check("R8 no overrun in range", int'(ovr), 0);

    // R8: busy 117 over period 100, line lasts 117, flag sticky
    do_reset();
    fill(5);
    setcfg(16, 3, 0, 2, 5, 4, 100);
    p1 = 3; tagx = "/R8";
    kick();
    check("R8 busy", e_B, 117);
    check_line(e_peff);
    p1 = -1;
    calc();
    check_line(e_peff + 2);
    check("R8 ovr set", int'(ovr), 1);
    repeat (5) @(negedge clk);
    check("R8 ovr sticky", int'(ovr), 1);

    // R8: busy exactly equal to period gives no overrun
    do_reset();
    setcfg(10, 2, 0, 1, 4, 3, 50);
    kick();
    check("R8 equal busy", e_B, 50);
    check_line(e_peff + 2);
    check("R8 ovr equal", int'(ovr), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule